// File: doc/BRIEF.md
# Serial Flash Status-Register Write Guard

This block is the slave-side command logic that guards the protection register of a serial flash. It oversamples the chip-enable, serial clock and serial data pins with the system clock and assembles 8-bit opcodes and data bytes. It holds a protection register with three block-protect bits and a lock bit. A register-write command changes that register only when the command framed just before it was an arming command. The write-protect pin and the lock bit together decide whether the write commits. A write that is allowed takes effect on the rising edge of chip-enable that closes its frame.

Surrounding flash logic reads the protection register through `status_o`. The block has no array, erase, readout-shifting or busy logic. The opcodes are parameters. By default the arming opcodes are 0x50 and 0x06 and the register-write opcode is 0x01.

Top module: `sr_write_guard`

## Requirements
- R1: After reset `status_o` is 0x00.
- R2: The register-write data byte maps bit 2 to BP0, bit 3 to BP1, bit 4 to BP2 and bit 7 to the lock bit. All other bits of `status_o` read 0 and ignore written values, so writing 0xFF yields 0x9C.
- R3: `si` is sampled MSB first on each rising edge of `sck` while `ce_n` is low. Both clock idle levels work: low (mode 0) and high (mode 3).
- R4: A register write (opcode 0x01 followed by a data byte) commits only if the frame just before it carried an arming opcode, 0x50 or 0x06. Otherwise the write is ignored.
- R5: The arming state is consumed by any register-write attempt, whether or not it commits. Any other well-formed frame whose opcode is not an arming opcode also clears it.
- R6: A register write changes `status_o` only after `ce_n` rises at the end of its frame, never while `ce_n` is still low.
- R7: While `wp_n` is low and the lock bit is 1, a register write leaves `status_o` unchanged.
- R8: While `wp_n` is low and the lock bit is 0, an armed write updates all four bits. It can set the lock bit and change BP0 to BP2 in the same operation.
- R9: While `wp_n` is high, locking is disabled and an armed write may change all four bits, including clearing the lock bit.
- R10: A frame whose bit count is zero or not a multiple of 8, or a register write shorter than 16 bits, is discarded when `ce_n` rises. Such a frame also clears the arming state.
- R11: Bytes after the first data byte of a register write are ignored. The first data byte is the one written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low; a low period frames one command |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Protection register: BPL bit 7, BP2 bit 4, BP1 bit 3, BP0 bit 2 |

## Verification
The bench goes after the arming rule in several forms: a write without an arm, an unrelated frame placed between the arm and the write, and a second write made without re-arming. A design that keeps the arm alive too long would commit in these cases, and the bench would see a changed register. It tries the lock in both directions of `wp_n`. With `wp_n` high the lock bit must clear; with `wp_n` low a locked register must not move, and a sticky-bit error shows up as a changed value. It sends truncated frames, an arm cut to 7 bits and a 24-bit write, which catch a decoder that counts bits wrongly or takes the last byte instead of the first. It also reads the register while `ce_n` is still low after a full write, which exposes a design that commits on the last bit.

// File: rtl/sr_write_guard.sv
module sr_write_guard #(
  parameter logic [7:0] ARM_OP  = 8'h50,
  parameter logic [7:0] WREN_OP = 8'h06,
  parameter logic [7:0] WR_OP   = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       sck,
  input  logic       si,
  input  logic       wp_n,
  output logic [7:0] status_o
);
  localparam logic [7:0] WMASK = 8'h9C;

  logic ce_s, ce_d, sck_s, sck_d, si_s, wp_s;
  logic [2:0] bitpos;
  logic [1:0] nbytes;
  logic [6:0] sh;
  logic [7:0] opcode, data, status;
  logic armed;

  wire sck_rise = !ce_s && sck_s && !sck_d;
  wire ce_fall  = !ce_s && ce_d;
  wire ce_rise  = ce_s && !ce_d;
  wire [7:0] next_byte = {sh, si_s};

  wire frame_ok = (bitpos == 3'd0) && (nbytes != 2'd0);
  wire is_arm   = (opcode == ARM_OP) || (opcode == WREN_OP);
  wire is_wr    = (opcode == WR_OP);
  wire commit   = frame_ok && is_wr && (nbytes >= 2'd2) && armed && (wp_s || !status[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_s  <= 1'b1;
      ce_d  <= 1'b1;
      sck_s <= 1'b0;
      sck_d <= 1'b0;
      si_s  <= 1'b0;
      wp_s  <= 1'b0;
    end else begin
      ce_s  <= ce_n;
      ce_d  <= ce_s;
      sck_s <= sck;
      sck_d <= sck_s;
      si_s  <= si;
      wp_s  <= wp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitpos <= '0;
      nbytes <= '0;
      sh     <= '0;
      opcode <= '0;
      data   <= '0;
    end else if (ce_fall) begin
      bitpos <= '0;
      nbytes <= '0;
    end else if (sck_rise) begin
      sh     <= next_byte[6:0];
      bitpos <= bitpos + 3'd1;
      if (bitpos == 3'd7) begin
        if (nbytes == 2'd0) opcode <= next_byte;
        if (nbytes == 2'd1) data   <= next_byte;
        if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      status <= '0;
    end else if (ce_rise) begin
      armed <= frame_ok && is_arm;
      if (commit) status <= data & WMASK;
    end
  end

  assign status_o = status;
endmodule

module sr_write_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_rise,
  input logic       armed,
  input logic       wp_s,
  input logic [7:0] status
);
  a_r6_change_only_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_rise |=> $stable(status));
  a_r4_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_rise && !armed) |=> $stable(status));
  a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_rise && !wp_s && status[7]) |=> $stable(status));
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_s && status[7]) |=> status[7]);
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |=> ((status & 8'h63) == 8'h00));
endmodule

bind sr_write_guard sr_write_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_rise(ce_rise), .armed(armed),
  .wp_s(wp_s), .status(status)
);

// File: tb/sim_sr_write_guard.sv
module sim_sr_write_guard;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int NV = 7;
  // [26] arm, [25:18] arm opcode, [17] wp_n, [16] mode3, [15:8] data, [7:0] expected
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 8'h06, 1'b1, 1'b0, 8'hFF, 8'h9C},  // R2 R9
    {1'b1, 8'h50, 1'b1, 1'b1, 8'h08, 8'h08},  // R3 R9
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h1C, 8'h08},  // R4
    {1'b1, 8'h50, 1'b0, 1'b1, 8'h84, 8'h84},  // R8
    {1'b1, 8'h50, 1'b0, 1'b0, 8'h00, 8'h84},  // R7
    {1'b1, 8'h06, 1'b1, 1'b1, 8'h10, 8'h10},  // R9
    {1'b1, 8'h50, 1'b0, 1'b0, 8'h0C, 8'h0C}   // R8
  };

  logic clk = 0, rst_n = 0, ce_n = 1, sck = 0, si = 0, wp_n = 1;
  logic [7:0] status_o;
  int checks = 0, fails = 0;
  bit done = 0;

  sr_write_guard u0 (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sck(sck),
                     .si(si), .wp_n(wp_n), .status_o(status_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(logic [7:0] exp, string req);
    checks++;
    if (status_o !== exp) begin
      fails++;
      $display("FAIL %s: status_o=%h expected %h", req, status_o, exp);
    end
  endtask

  task automatic begin_frame(bit m3);
    sck = m3;
    waitc(HALF);
    ce_n = 0;
    waitc(HALF);
  endtask

  task automatic shift(int n, logic [23:0] v);
    for (int i = n - 1; i >= 0; i--) begin
      sck = 0; si = v[i]; waitc(HALF);
      sck = 1; waitc(HALF);
    end
  endtask

  task automatic end_frame(bit m3);
    sck = m3;
    waitc(HALF);
    ce_n = 1;
    waitc(8);
  endtask

  task automatic frame(bit m3, int n, logic [23:0] v);
    begin_frame(m3);
    shift(n, v);
    end_frame(m3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    waitc(4);
    rst_n = 1;
    waitc(2);
    check(8'h00, "R1 reset");

    for (int k = 0; k < NV; k++) begin
      wp_n = VEC[k][17];
      if (VEC[k][26]) frame(VEC[k][16], 8, {16'h0, VEC[k][25:18]});
      frame(VEC[k][16], 16, {8'h0, 8'h01, VEC[k][15:8]});
      check(VEC[k][7:0], $sformatf("R3 R4 vector %0d", k));
    end

    wp_n = 1;
    frame(0, 8, 24'h50);
    frame(0, 8, 24'h05);
    frame(0, 16, 24'h0110);
    check(8'h0C, "R5 other opcode clears arm");

    frame(1, 8, 24'h50);
    frame(1, 12, 24'h011);
    check(8'h0C, "R10 short write discarded");
    frame(1, 16, 24'h0110);
    check(8'h0C, "R10 short write clears arm");

    frame(0, 7, 24'h28);
    frame(0, 16, 24'h0110);
    check(8'h0C, "R10 7-bit arm ignored");

    frame(0, 8, 24'h06);
    frame(0, 8, 24'h01);
    frame(0, 16, 24'h0110);
    check(8'h0C, "R10 write without data clears arm");

    frame(0, 8, 24'h06);
    begin_frame(0);
    frame(0, 0, 24'h0);
    check(8'h0C, "R10 empty frame setup");
    end_frame(0);
    frame(0, 16, 24'h0110);
    check(8'h0C, "R10 empty frame clears arm");

    frame(0, 8, 24'h50);
    begin_frame(0);
    shift(16, 24'h0110);
    sck = 0;
    waitc(8);
    check(8'h0C, "R6 no change before ce_n rises");
    ce_n = 1;
    waitc(8);
    check(8'h10, "R6 commit after ce_n rises");

    frame(1, 8, 24'h06);
    frame(1, 24, 24'h0184FF);
    check(8'h84, "R11 extra byte ignored");

    frame(1, 16, 24'h0100);
    check(8'h84, "R5 arm consumed by write");

    frame(0, 8, 24'h50);
    frame(0, 16, 24'h0100);
    check(8'h00, "R9 lock cleared with wp_n high");

    wp_n = 0;
    frame(0, 8, 24'h50);
    frame(0, 16, 24'h0180);
    frame(0, 8, 24'h50);
    frame(0, 16, 24'h0100);
    check(8'h80, "R7 lock cannot clear with wp_n low");

    rst_n = 0;
    waitc(2);
    rst_n = 1;
    waitc(2);
    check(8'h00, "R1 reset after use");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule